// File: doc/BRIEF.md
# Interrupt Entry Flag Manager

This block keeps a processor's 32-bit status-flag word and changes it when control passes into an interrupt or exception handler and back out. An entry strobe pushes the live word onto a small internal save stack. It then clears the trace, virtual-mode, resume and nested-task flags. The interrupt-enable flag is cleared as well, but only if the entry goes through an interrupt-type gate; a trap-type gate leaves it alone. A return strobe pops the most recent saved word and puts it back as the live word, which restores every flag the entry had cleared.

Entries nest up to the depth of the save stack. A load port stands in for ordinary writes to the flag word by the rest of the core, so the word can take any value between entries. All control pins are plain single-cycle strobes; no data stream crosses the boundary, so there is no valid/ready handshake. Each updated word appears on `flags_o` one clock after the strobe that caused it.

Top module: `irq_flag_keeper`

## Requirements
- R1: After reset `flags_o` is 32'h0000_0002, `stk_empty_o` is 1, `stk_full_o` is 0, and `ovf_o`, `unf_o` and `gate_err_o` are 0.
- R2: An accepted entry saves the whole flag word as it stood before the entry changed it.
- R3: One clock after an accepted entry, trace (bit 8), nested-task (bit 14), resume (bit 16) and virtual-mode (bit 17) read 0. Every other bit except interrupt-enable keeps its pre-entry value.
- R4: On an accepted entry with `gate_i` = 2'b00 (interrupt gate), interrupt-enable (bit 9) reads 0 one clock later.
- R5: On an accepted entry with `gate_i` = 2'b01 (trap gate), interrupt-enable keeps its pre-entry value.
- R6: An accepted return makes `flags_o` equal to the most recently saved word one clock later. Nested entries are undone in last-in, first-out order.
- R7: The save stack holds 8 words, and `stk_full_o` is 1 exactly when 8 words are held. An entry with a valid gate while the stack is full produces a one-cycle `ovf_o` pulse and changes neither `flags_o` nor the stack.
- R8: A return while the stack is empty, with no entry in the same cycle, produces a one-cycle `unf_o` pulse and leaves `flags_o` unchanged.
- R9: An entry with `gate_i` of 2'b10 or 2'b11 produces a one-cycle `gate_err_o` pulse and changes neither `flags_o` nor the stack.
- R10: When entry and return strobes arrive in the same cycle, the entry is carried out and the return is ignored; it raises no underflow.
- R11: A load with neither strobe present sets `flags_o` to `load_data_i` with bit 1 forced to 1, one clock later. A load in the same cycle as either strobe is ignored.
- R12: Bit 1 of `flags_o` always reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enter_i | input | 1 | Handler entry strobe |
| leave_i | input | 1 | Handler return strobe |
| gate_i | input | 2 | Gate type for entry: 00 interrupt, 01 trap |
| load_i | input | 1 | Load strobe for the flag word |
| load_data_i | input | 32 | Value to load |
| flags_o | output | 32 | Live flag word |
| stk_full_o | output | 1 | Save stack holds its maximum |
| stk_empty_o | output | 1 | Save stack holds nothing |
| ovf_o | output | 1 | One-cycle pulse: entry refused, stack full |
| unf_o | output | 1 | One-cycle pulse: return refused, stack empty |
| gate_err_o | output | 1 | One-cycle pulse: entry refused, bad gate code |

## Verification
A wrong stack pointer or a corrupted stack slot shows up on the first return that reads it: `flags_o` differs from the word live before the matching entry, one clock after the return strobe. A miscounted depth appears at the stack-status pins. It moves `stk_full_o` or `stk_empty_o` one entry early or late, and the eighth push or the extra pop then produces the wrong pulse. A wrong mask or wrong gate decode is visible on `flags_o` in the very cycle after the entry. The bench sweeps all 32 settings of the five managed bits against both gate codes for this reason, and it also fills and drains the full stack depth.

// File: rtl/flagkeep_pkg.sv
package flagkeep_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned BIT_TRC  = 8;
  localparam int unsigned BIT_IEN  = 9;
  localparam int unsigned BIT_NST  = 14;
  localparam int unsigned BIT_RSM  = 16;
  localparam int unsigned BIT_VRT  = 17;
  localparam int unsigned BIT_ONE  = 1;

  typedef enum logic [1:0] {
    GATE_INTR = 2'b00,
    GATE_TRAP = 2'b01
  } gate_e;

  localparam logic [WORD_W-1:0] RESET_WORD = WORD_W'(1) << BIT_ONE;
  localparam logic [WORD_W-1:0] ALWAYS_CLR =
      (WORD_W'(1) << BIT_TRC) | (WORD_W'(1) << BIT_NST) |
      (WORD_W'(1) << BIT_RSM) | (WORD_W'(1) << BIT_VRT);
  localparam logic [WORD_W-1:0] IEN_MASK = WORD_W'(1) << BIT_IEN;
endpackage

// File: rtl/entry_mask_calc.sv
module entry_mask_calc
  import flagkeep_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic [W-1:0] cur_i,
  input  logic [1:0]   gate_i,
  output logic [W-1:0] next_o,
  output logic         gate_ok_o
);
  logic [W-1:0] clr_mask;

  always_comb begin
    clr_mask  = W'(ALWAYS_CLR);
    gate_ok_o = 1'b1;
    unique case (gate_i)
      GATE_INTR: clr_mask = W'(ALWAYS_CLR) | W'(IEN_MASK);
      GATE_TRAP: clr_mask = W'(ALWAYS_CLR);
      default:   gate_ok_o = 1'b0;
    endcase
    next_o = cur_i & ~clr_mask;
  end
endmodule

// File: rtl/flag_save_stack.sv
module flag_save_stack #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] push_data_i,
  output logic [W-1:0] top_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  slots [DEPTH];
  logic [CW-1:0] fill_q;
  logic [CW-1:0] fill_dec;
  logic [AW-1:0] wr_idx;
  logic [AW-1:0] rd_idx;

  assign fill_dec = fill_q - CW'(1);
  assign wr_idx   = fill_q[AW-1:0];
  assign rd_idx   = fill_dec[AW-1:0];
  assign full_o   = (fill_q == CW'(DEPTH));
  assign empty_o  = (fill_q == '0);
  assign top_o    = slots[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= '0;
    end else if (push_i && !full_o) begin
      fill_q <= fill_q + CW'(1);
    end else if (pop_i && !empty_o) begin
      fill_q <= fill_dec;
    end
  end

  always_ff @(posedge clk) begin
    if (push_i && !full_o) slots[wr_idx] <= push_data_i;
  end
endmodule

// File: rtl/irq_flag_keeper.sv
module irq_flag_keeper
  import flagkeep_pkg::*;
#(
  parameter int unsigned W     = WORD_W,
  parameter int unsigned DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enter_i,
  input  logic         leave_i,
  input  logic [1:0]   gate_i,
  input  logic         load_i,
  input  logic [W-1:0] load_data_i,
  output logic [W-1:0] flags_o,
  output logic         stk_full_o,
  output logic         stk_empty_o,
  output logic         ovf_o,
  output logic         unf_o,
  output logic         gate_err_o
);
  localparam logic [W-1:0] ONE_BIT = W'(1) << BIT_ONE;

  logic [W-1:0] flags_q;
  logic [W-1:0] masked;
  logic [W-1:0] top_word;
  logic         gate_ok;
  logic         do_enter, do_leave, do_load;
  logic         bad_gate, too_deep, too_shallow;

  entry_mask_calc #(.W(W)) u_mask (
    .cur_i     (flags_q),
    .gate_i    (gate_i),
    .next_o    (masked),
    .gate_ok_o (gate_ok)
  );

  flag_save_stack #(.W(W), .DEPTH(DEPTH)) u_stack (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (do_enter),
    .pop_i       (do_leave),
    .push_data_i (flags_q),
    .top_o       (top_word),
    .full_o      (stk_full_o),
    .empty_o     (stk_empty_o)
  );

  always_comb begin
    bad_gate    = enter_i && !gate_ok;
    too_deep    = enter_i && gate_ok && stk_full_o;
    do_enter    = enter_i && gate_ok && !stk_full_o;
    do_leave    = leave_i && !enter_i && !stk_empty_o;
    too_shallow = leave_i && !enter_i && stk_empty_o;
    do_load     = load_i && !enter_i && !leave_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q    <= W'(RESET_WORD);
      ovf_o      <= 1'b0;
      unf_o      <= 1'b0;
      gate_err_o <= 1'b0;
    end else begin
      ovf_o      <= too_deep;
      unf_o      <= too_shallow;
      gate_err_o <= bad_gate;
      if (do_enter)      flags_q <= masked | ONE_BIT;
      else if (do_leave) flags_q <= top_word | ONE_BIT;
      else if (do_load)  flags_q <= load_data_i | ONE_BIT;
    end
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/irq_flag_keeper_chk.sv
module irq_flag_keeper_chk
  import flagkeep_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input logic         clk,
  input logic         rst_n,
  input logic         enter_i,
  input logic         leave_i,
  input logic [1:0]   gate_i,
  input logic         load_i,
  input logic [W-1:0] load_data_i,
  input logic [W-1:0] flags_o,
  input logic         stk_full_o,
  input logic         stk_empty_o,
  input logic         ovf_o,
  input logic         unf_o,
  input logic         gate_err_o
);
  logic valid_gate;
  assign valid_gate = (gate_i == GATE_INTR) || (gate_i == GATE_TRAP);

  // R3
  always_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enter_i && valid_gate && !stk_full_o |=> (flags_o & W'(ALWAYS_CLR)) == '0);

  // R4
  intr_gate_ien_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enter_i && gate_i == GATE_INTR && !stk_full_o |=> !flags_o[BIT_IEN]);

  // R5
  trap_gate_ien_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enter_i && gate_i == GATE_TRAP && !stk_full_o |=> flags_o[BIT_IEN] == $past(flags_o[BIT_IEN]));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enter_i && valid_gate && stk_full_o |=> ovf_o && $stable(flags_o));

  // R8
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    leave_i && !enter_i && stk_empty_o |=> unf_o && $stable(flags_o));

  // R9
  bad_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enter_i && !valid_gate |=> gate_err_o && $stable(flags_o) && $stable(stk_empty_o));

  // R10
  entry_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enter_i && leave_i |=> !unf_o);

  // R11
  load_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i && !enter_i && !leave_i |=> flags_o == ($past(load_data_i) | W'(RESET_WORD)));

  // R12
  fixed_one_chk: assert property (@(posedge clk) disable iff (!rst_n) flags_o[BIT_ONE]);

  // R7
  full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(stk_full_o && stk_empty_o));
endmodule

bind irq_flag_keeper irq_flag_keeper_chk #(.W(W)) u_chk (.*);

// File: tb/irq_flag_keeper_tb.sv
`timescale 1ns/1ps
module irq_flag_keeper_tb;
  localparam logic [31:0] CLR5 = 32'h0003_4100;
  localparam logic [31:0] IEN  = 32'h0000_0200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enter_i = 1'b0, leave_i = 1'b0, load_i = 1'b0;
  logic [1:0]  gate_i = 2'b00;
  logic [31:0] load_data_i = '0;
  logic [31:0] flags_o;
  logic        stk_full_o, stk_empty_o, ovf_o, unf_o, gate_err_o;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic [31:0] m_flags;
  logic [31:0] m_stk [8];
  int          m_cnt;

  always #2.5 clk = ~clk;

  irq_flag_keeper u_dut (
    .clk(clk), .rst_n(rst_n), .enter_i(enter_i), .leave_i(leave_i),
    .gate_i(gate_i), .load_i(load_i), .load_data_i(load_data_i),
    .flags_o(flags_o), .stk_full_o(stk_full_o), .stk_empty_o(stk_empty_o),
    .ovf_o(ovf_o), .unf_o(unf_o), .gate_err_o(gate_err_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one cycle of stimulus, update the model, check all outputs.
  task automatic op(string tag, bit en, bit lv, logic [1:0] g, bit ld, logic [31:0] d);
    bit e_ovf = 0, e_unf = 0, e_err = 0;
    enter_i = en; leave_i = lv; gate_i = g; load_i = ld; load_data_i = d;
    if (en) begin
      if (g > 2'b01) e_err = 1;
      else if (m_cnt == 8) e_ovf = 1;
      else begin
        m_stk[m_cnt] = m_flags;
        m_cnt++;
        m_flags = m_flags & ~CLR5 & ((g == 2'b00) ? ~IEN : 32'hFFFF_FFFF);
      end
    end else if (lv) begin
      if (m_cnt == 0) e_unf = 1;
      else begin
        m_cnt--;
        m_flags = m_stk[m_cnt];
      end
    end else if (ld) begin
      m_flags = d | 32'h2;
    end
    @(negedge clk);
    enter_i = 0; leave_i = 0; load_i = 0;
    chk(tag, flags_o, m_flags);
    chk("R7 ovf", {31'b0, ovf_o}, {31'b0, e_ovf});
    chk("R8 unf", {31'b0, unf_o}, {31'b0, e_unf});
    chk("R9 gate_err", {31'b0, gate_err_o}, {31'b0, e_err});
    chk("R7 full", {31'b0, stk_full_o}, {31'b0, m_cnt == 8});
    chk("R1 empty", {31'b0, stk_empty_o}, {31'b0, m_cnt == 0});
    chk("R12 bit1", {31'b0, flags_o[1]}, 32'd1);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    m_flags = 32'h2;
    m_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 flags", flags_o, 32'h0000_0002);
    chk("R1 empty", {31'b0, stk_empty_o}, 32'd1);
    chk("R1 full", {31'b0, stk_full_o}, 32'd0);
    chk("R1 pulses", {29'b0, ovf_o, unf_o, gate_err_o}, 32'd0);

    // Sweep the five managed bits against both gates: load (R11), enter (R3/R4/R5), return (R2/R6).
    for (int c = 0; c < 32; c++) begin
      for (int g = 0; g < 2; g++) begin
        logic [31:0] w;
        w = ((32'(c) * 32'h9E37_79B9) & ~(CLR5 | IEN)) |
            (32'(c & 1) << 8) | (32'((c >> 1) & 1) << 9) | (32'((c >> 2) & 1) << 14) |
            (32'((c >> 3) & 1) << 16) | (32'((c >> 4) & 1) << 17);
        op("R11 load", 0, 0, 2'b00, 1, w);
        op(g == 0 ? "R4 intr entry" : "R5 trap entry", 1, 0, 2'(g), 0, 32'h0);
        op("R3 entry mask", 0, 0, 2'b00, 0, 32'h0);
        op("R6 return", 0, 1, 2'b00, 0, 32'h0);
        op("R2 saved word", 0, 0, 2'b00, 0, 32'h0);
      end
    end

    // Nest to full depth with a fresh load before each entry (R6, R7).
    for (int k = 0; k < 8; k++) begin
      op("R11 load", 0, 0, 2'b00, 1, 32'hFFFF_FFFF - 32'(k * 32'h0001_1203));
      op("R5 nested entry", 1, 0, 2'(k & 1), 0, 32'h0);
    end
    op("R7 overflow", 1, 0, 2'b01, 0, 32'h0);
    op("R9 bad gate 10", 1, 0, 2'b10, 0, 32'h0);
    op("R11 load with entry ignored", 1, 0, 2'b11, 1, 32'h1234_5678);
    for (int k = 0; k < 8; k++) op("R6 unwind", 0, 1, 2'b00, 0, 32'h0);
    op("R8 underflow", 0, 1, 2'b00, 0, 32'h0);
    op("R11 load with return ignored", 0, 1, 2'b00, 1, 32'hABCD_EF01);

    // Entry and return together: entry wins (R10).
    op("R11 load", 0, 0, 2'b00, 1, 32'h0003_4300);
    op("R10 both strobes", 1, 1, 2'b00, 0, 32'h0);
    op("R10 both strobes again", 1, 1, 2'b01, 0, 32'h0);
    op("R9 bad gate 11", 1, 0, 2'b11, 0, 32'h0);
    op("R6 return", 0, 1, 2'b00, 0, 32'h0);
    op("R6 return", 0, 1, 2'b00, 0, 32'h0);
    op("R8 underflow", 0, 1, 2'b00, 0, 32'h0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule